// File: doc/BRIEF.md
# Global Compare Timer

This block is a memory-mapped system timer. A 64-bit counter runs on the block clock once its run bit is set. Software can preload it as two 32-bit words while it is stopped. A single 64-bit comparator watches the counter. When the two are equal, and the comparator is enabled, a sticky pending flag is set. That flag drives the interrupt output whenever the interrupt enable bit is set. In auto-advance mode the comparator adds a 32-bit step to its own value on every match, which gives periodic interrupts with no reload from software.

Writes to the timing registers (the counter words, the compare words, the step and the control register) are not applied at once. They pass through a fixed delay line, which models the crossing into a slow timer clock. Each such register has a sticky write-done bit that software polls and then clears by writing 1 to it. The counter words are read one at a time, so software reads high, then low, then high again and retries on a mismatch. The counter itself is one 64-bit register, so a carry never shows up in one word without the other.

Top module: `gct_timer`

## Requirements
- R1: After reset, the counter, compare value, step, control, interrupt enable, pending flag and both write-done registers read as zero, and `irq` is low.
- R2: A write to a timing register is sampled on one rising edge and takes effect on the 4th rising edge after it (parameter LAT). Reads before that edge return the old value. Word offsets: 0 counter low, 1 counter high, 2 compare low, 3 compare high, 4 step, 5 control.
- R3: The write-done bits set on the edge where their write takes effect, stay set, and clear when 1 is written to them. Offset 6 holds compare low at bit 0, compare high at bit 1, step at bit 2 and control at bit 16. Offset 7 holds counter low at bit 0 and counter high at bit 1. If a set and a clear fall on the same edge, the set wins.
- R4: With control bit 0 (run) set, the counter increases by one on every edge. With it clear, the counter holds its value. A counter word write that takes effect replaces that word and suppresses the increment on that edge.
- R5: The counter carries from its low word into its high word on the same edge, so a low word of FFFF_FFFF followed by one increment reads low 0 and high +1.
- R6: While control bit 1 (compare enable) and the run bit are both set, and the counter equals the compare value, the pending flag sets on the next edge. The pending flag is read at bit 0 of offset 9.
- R7: With control bit 2 (auto-advance) set, each match adds the step register, zero-extended, to the 64-bit compare value on the same edge that sets pending.
- R8: `irq` is high exactly when the pending flag and bit 0 of offset 8 (interrupt enable) are both set. Writing 1 to bit 0 of offset 9 clears pending on the next edge. Offsets 8 and 9 act without the delay.
- R9: Clearing compare enable stops new matches but leaves a pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Compare interrupt, level |

## Verification
The assertions assume that at most one write per cycle reaches the block. This means the delay line delivers at most one applied write per edge. They also assume that nothing but a match or a counter-word write moves the counter and the compare value. The stimulus changes the compare words and the step only while compare enable is clear, and it loads the counter only while it is stopped. With that discipline, every match cycle and every applied write falls on a cycle the bench can compute in advance. The random phase draws only offsets and data, never the timing of the delay line.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int REG_AW = 4;
  localparam int DW     = 32;
  localparam int CW     = 64;

  typedef enum logic [REG_AW-1:0] {
    A_CNT_LO  = 4'd0,
    A_CNT_HI  = 4'd1,
    A_CMP_LO  = 4'd2,
    A_CMP_HI  = 4'd3,
    A_STEP    = 4'd4,
    A_CTRL    = 4'd5,
    A_CFG_WST = 4'd6,
    A_CNT_WST = 4'd7,
    A_IRQ_EN  = 4'd8,
    A_IRQ_ST  = 4'd9
  } reg_addr_e;

  typedef struct packed {
    logic            vld;
    logic [REG_AW-1:0] idx;
    logic [DW-1:0]   data;
  } wr_slot_t;

  typedef struct packed {
    logic auto_inc;
    logic cmp_en;
    logic run;
  } ctrl_t;

  function automatic logic is_delayed(input logic [REG_AW-1:0] a);
    return a <= A_CTRL;
  endfunction

  function automatic logic [CW-1:0] cmp_advance(input logic [CW-1:0] cmp,
                                                input logic [DW-1:0] step);
    return cmp + {{(CW-DW){1'b0}}, step};
  endfunction

  function automatic logic [CW-1:0] put_word(input logic [CW-1:0] cur,
                                             input logic hi,
                                             input logic [DW-1:0] d);
    logic [CW-1:0] r;
    r = cur;
    if (hi) r[CW-1:DW] = d;
    else    r[DW-1:0]  = d;
    return r;
  endfunction
endpackage

// File: rtl/gct_wr_pipe.sv
module gct_wr_pipe
  import gct_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  wr_slot_t in_slot,
  output wr_slot_t out_slot
);
  localparam int LAST = LAT - 1;

  wr_slot_t stg [LAT];

  generate
    for (genvar i = 0; i < LAT; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else if (i == 0) stg[i] <= in_slot;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign out_slot = stg[LAST];
endmodule

// File: rtl/gct_counter.sv
module gct_counter
  import gct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [DW-1:0] ld_data,
  output logic [CW-1:0] cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (ld_lo || ld_hi) cnt_q <= put_word(cnt_q, ld_hi, ld_data);
    else if (run)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gct_comparator.sv
module gct_comparator
  import gct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          armed,
  input  logic          auto_inc,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          ld_step,
  input  logic [DW-1:0] ld_data,
  output logic [CW-1:0] cmp_q,
  output logic [DW-1:0] step_q,
  output logic          match_ev
);
  assign match_ev = armed && (cnt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cmp_q <= '0;
    else if (ld_lo || ld_hi)        cmp_q <= put_word(cmp_q, ld_hi, ld_data);
    else if (match_ev && auto_inc)  cmp_q <= cmp_advance(cmp_q, step_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (ld_step) step_q <= ld_data;
  end
endmodule

// File: rtl/gct_timer.sv
module gct_timer
  import gct_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  wr_slot_t      in_slot, ap_slot;
  ctrl_t         ctrl_q;
  logic [CW-1:0] cnt_q, cmp_q;
  logic [DW-1:0] step_q;
  logic          match_ev, pending_q, irq_en_q;
  logic [3:0]    cfg_wst_q;   // {ctrl, step, cmp_hi, cmp_lo}
  logic [1:0]    cnt_wst_q;   // {cnt_hi, cnt_lo}

  // applied-write strobes, brought out for the checker
  logic ap_cnt_lo, ap_cnt_hi, ap_cmp_lo, ap_cmp_hi, ap_step, ap_ctrl;
  logic wr_cfg_wst, wr_cnt_wst, wr_irq_en, clr_pend;

  assign in_slot.vld  = bus_we && is_delayed(bus_addr);
  assign in_slot.idx  = bus_addr;
  assign in_slot.data = bus_wdata;

  gct_wr_pipe #(.LAT(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_slot(in_slot), .out_slot(ap_slot)
  );

  assign ap_cnt_lo = ap_slot.vld && (ap_slot.idx == A_CNT_LO);
  assign ap_cnt_hi = ap_slot.vld && (ap_slot.idx == A_CNT_HI);
  assign ap_cmp_lo = ap_slot.vld && (ap_slot.idx == A_CMP_LO);
  assign ap_cmp_hi = ap_slot.vld && (ap_slot.idx == A_CMP_HI);
  assign ap_step   = ap_slot.vld && (ap_slot.idx == A_STEP);
  assign ap_ctrl   = ap_slot.vld && (ap_slot.idx == A_CTRL);

  assign wr_cfg_wst = bus_we && (bus_addr == A_CFG_WST);
  assign wr_cnt_wst = bus_we && (bus_addr == A_CNT_WST);
  assign wr_irq_en  = bus_we && (bus_addr == A_IRQ_EN);
  assign clr_pend   = bus_we && (bus_addr == A_IRQ_ST) && bus_wdata[0];

  gct_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run),
    .ld_lo(ap_cnt_lo), .ld_hi(ap_cnt_hi), .ld_data(ap_slot.data),
    .cnt_q(cnt_q)
  );

  gct_comparator u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_q),
    .armed(ctrl_q.cmp_en && ctrl_q.run), .auto_inc(ctrl_q.auto_inc),
    .ld_lo(ap_cmp_lo), .ld_hi(ap_cmp_hi), .ld_step(ap_step),
    .ld_data(ap_slot.data), .cmp_q(cmp_q), .step_q(step_q),
    .match_ev(match_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ap_ctrl) ctrl_q <= ap_slot.data[2:0];
  end

  // sticky write-done bits: set wins over a same-edge clear
  logic [3:0] cfg_clr, cfg_set;
  logic [1:0] cnt_clr, cnt_set;
  assign cfg_clr = wr_cfg_wst ? {bus_wdata[16], bus_wdata[2:0]} : 4'b0;
  assign cfg_set = {ap_ctrl, ap_step, ap_cmp_hi, ap_cmp_lo};
  assign cnt_clr = wr_cnt_wst ? bus_wdata[1:0] : 2'b0;
  assign cnt_set = {ap_cnt_hi, ap_cnt_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_wst_q <= '0;
      cnt_wst_q <= '0;
    end else begin
      cfg_wst_q <= (cfg_wst_q & ~cfg_clr) | cfg_set;
      cnt_wst_q <= (cnt_wst_q & ~cnt_clr) | cnt_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_en_q <= 1'b0;
    else if (wr_irq_en) irq_en_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending_q <= 1'b0;
    else if (match_ev) pending_q <= 1'b1;
    else if (clr_pend) pending_q <= 1'b0;
  end

  assign irq = pending_q && irq_en_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO:  bus_rdata = cnt_q[DW-1:0];
      A_CNT_HI:  bus_rdata = cnt_q[CW-1:DW];
      A_CMP_LO:  bus_rdata = cmp_q[DW-1:0];
      A_CMP_HI:  bus_rdata = cmp_q[CW-1:DW];
      A_STEP:    bus_rdata = step_q;
      A_CTRL:    bus_rdata = {29'd0, ctrl_q};
      A_CFG_WST: bus_rdata = {15'd0, cfg_wst_q[3], 13'd0, cfg_wst_q[2:0]};
      A_CNT_WST: bus_rdata = {30'd0, cnt_wst_q};
      A_IRQ_EN:  bus_rdata = {31'd0, irq_en_q};
      A_IRQ_ST:  bus_rdata = {31'd0, pending_q};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gct_checker.sv
module gct_checker
  import gct_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          cmp_en,
  input logic          auto_inc,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp,
  input logic [DW-1:0] step,
  input logic          ld_cnt,
  input logic          ld_cmp,
  input logic          ap_cmp_lo,
  input logic          ap_cnt_hi,
  input logic [3:0]    cfg_wst,
  input logic [1:0]    cnt_wst,
  input logic          match_ev,
  input logic          pending,
  input logic          clr_pend
);
  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    run && !ld_cnt |=> cnt == $past(cnt) + 64'd1); // R4

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !ld_cnt |=> $stable(cnt)); // R4

  AST_WST_CMP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    ap_cmp_lo |=> cfg_wst[0]); // R3

  AST_WST_CNT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ap_cnt_hi |=> cnt_wst[1]); // R3

  AST_MATCH_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> pending); // R6

  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev && auto_inc && !ld_cmp |=> cmp == $past(cmp) + {32'd0, $past(step)}); // R7

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !clr_pend |=> pending); // R8

  AST_OFF_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en && !pending |=> !pending); // R9
endmodule

bind gct_timer gct_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .run(ctrl_q.run), .cmp_en(ctrl_q.cmp_en), .auto_inc(ctrl_q.auto_inc),
  .cnt(cnt_q), .cmp(cmp_q), .step(step_q),
  .ld_cnt(ap_cnt_lo || ap_cnt_hi), .ld_cmp(ap_cmp_lo || ap_cmp_hi),
  .ap_cmp_lo(ap_cmp_lo), .ap_cnt_hi(ap_cnt_hi),
  .cfg_wst(cfg_wst_q), .cnt_wst(cnt_wst_q),
  .match_ev(match_ev), .pending(pending_q), .clr_pend(clr_pend)
);

// File: tb/gct_timer_bench.sv
module gct_timer_bench;
  localparam int LAT = 4;
  localparam logic [3:0] O_CNT_LO = 4'd0, O_CNT_HI = 4'd1, O_CMP_LO = 4'd2,
    O_CMP_HI = 4'd3, O_STEP = 4'd4, O_CTRL = 4'd5, O_CFG_WST = 4'd6,
    O_CNT_WST = 4'd7, O_IRQ_EN = 4'd8, O_IRQ_ST = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  gct_timer #(.LAT(LAT)) u_gct_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // expected write-done bit position for a delayed offset
  function automatic int wst_bit(input logic [3:0] a);
    if (a == O_CTRL) return 16;
    return int'(a) - 2;
  endfunction

  function automatic logic [63:0] adv(input logic [63:0] c, input logic [31:0] s, input int n);
    return c + 64'(s) * 64'(n);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    logic [31:0] shadow [6];
    logic [31:0] d;
    logic [3:0]  a;
    int          r;
    int unsigned seed;
    logic [63:0] cmpv;
    localparam int C = 40;
    localparam int S = 12;

    seed = 32'd7;
    r = $urandom(seed);
    for (int i = 0; i < 6; i++) shadow[i] = '0;

    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    for (int i = 0; i < 10; i++) chk_reg("R1 reset register", 4'(i), 32'd0);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);

    // R2 R3 random writes to compare words and step, comparator disabled
    for (int i = 0; i < 16; i++) begin
      r = $urandom_range(2, 4);
      a = 4'(r);
      d = $urandom();
      wr(a, d);
      step(LAT - 1);
      chk_reg("R2 old value before latency", a, shadow[a]);
      chk_reg("R3 write-done clear before apply", O_CFG_WST, 32'd0);
      step(1);
      shadow[a] = d;
      chk_reg("R2 new value after latency", a, d);
      chk_reg("R3 write-done set on apply", O_CFG_WST, 32'd1 << wst_bit(a));
      wr(O_CFG_WST, 32'd1 << wst_bit(a));
      chk_reg("R3 write-done cleared by one", O_CFG_WST, 32'd0);
    end

    // R4 R5 counter preload and carry
    wr(O_CNT_LO, 32'hFFFF_FFFE);
    wr(O_CNT_HI, 32'd5);
    step(LAT);
    chk_reg("R3 counter write-done bits", O_CNT_WST, 32'd3);
    wr(O_CNT_WST, 32'd1);
    chk_reg("R3 partial clear keeps other bit", O_CNT_WST, 32'd2);
    chk_reg("R4 preload low", O_CNT_LO, 32'hFFFF_FFFE);
    chk_reg("R4 stopped counter holds", O_CNT_HI, 32'd5);
    wr(O_CTRL, 32'd1);
    step(LAT);
    chk_reg("R4 value when run applies", O_CNT_LO, 32'hFFFF_FFFE);
    chk_reg("R3 control write-done bit 16", O_CFG_WST, 32'h0001_0000);
    step(1);
    chk_reg("R4 first increment", O_CNT_LO, 32'hFFFF_FFFF);
    step(1);
    chk_reg("R5 low wraps", O_CNT_LO, 32'd0);
    chk_reg("R5 high carries same edge", O_CNT_HI, 32'd6);
    step(10);
    chk_reg("R4 ten increments", O_CNT_LO, 32'd10);
    wr(O_CTRL, 32'd0);
    step(10);
    chk_reg("R4 stop holds value", O_CNT_LO, 32'd15);
    step(5);
    chk_reg("R4 still held", O_CNT_LO, 32'd15);

    // R6 R7 R8 periodic match
    wr(O_CNT_LO, 32'd0);
    wr(O_CNT_HI, 32'd0);
    wr(O_CMP_LO, C);
    wr(O_CMP_HI, 32'd0);
    wr(O_STEP, S);
    wr(O_IRQ_EN, 32'd1);
    step(LAT);
    chk("R8 no irq before match", {31'd0, irq}, 32'd0);
    wr(O_CTRL, 32'd7);
    step(LAT + C);
    chk_reg("R6 no pending on match cycle", O_IRQ_ST, 32'd0);
    step(1);
    chk_reg("R6 pending after match", O_IRQ_ST, 32'd1);
    chk("R8 irq with enable", {31'd0, irq}, 32'd1);
    cmpv = adv(64'(C), S, 1);
    chk_reg("R7 compare advanced by step", O_CMP_LO, cmpv[31:0]);
    wr(O_IRQ_ST, 32'd1);
    chk_reg("R8 pending cleared", O_IRQ_ST, 32'd0);
    chk("R8 irq drops", {31'd0, irq}, 32'd0);
    step(S - 2);
    chk_reg("R7 no early second match", O_IRQ_ST, 32'd0);
    step(1);
    chk_reg("R7 periodic second match", O_IRQ_ST, 32'd1);
    cmpv = adv(64'(C), S, 2);
    chk_reg("R7 compare advanced twice", O_CMP_LO, cmpv[31:0]);

    // R9 disable leaves pending, stops matches
    wr(O_CTRL, 32'd1);
    step(LAT);
    chk_reg("R9 pending unchanged by disable", O_IRQ_ST, 32'd1);
    wr(O_IRQ_ST, 32'd1);
    step(2 * S + 5);
    chk_reg("R9 no match while disabled", O_IRQ_ST, 32'd0);
    chk_reg("R9 compare not advanced", O_CMP_LO, cmpv[31:0]);

    // R8 enable gating, R6 one-shot without auto-advance
    wr(O_CTRL, 32'd0);
    step(LAT);
    wr(O_CNT_LO, 32'd100);
    wr(O_CNT_HI, 32'd0);
    wr(O_CMP_LO, 32'd110);
    wr(O_CMP_HI, 32'd0);
    wr(O_IRQ_EN, 32'd0);
    step(LAT);
    wr(O_CTRL, 32'd3);
    step(LAT + 10);
    chk_reg("R6 one-shot not yet", O_IRQ_ST, 32'd0);
    step(1);
    chk_reg("R6 one-shot pending", O_IRQ_ST, 32'd1);
    chk("R8 irq masked by enable", {31'd0, irq}, 32'd0);
    chk_reg("R7 no advance without auto bit", O_CMP_LO, 32'd110);
    wr(O_IRQ_EN, 32'd1);
    chk("R8 irq after enable", {31'd0, irq}, 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule